// File: doc/BRIEF.md
# In-Order Superscalar Dispatch Allocator

This block sits between a four-slot instruction buffer and six reservation stations. Every cycle it decides how many of the buffered instructions leave for their execution units. The instructions are taken oldest first, and the block stops at the first one that cannot go. The six target units are:

- branch
- load/store
- two simple integer units
- complex integer
- floating point

Each instruction that goes takes three kinds of entry:

- one entry in the reservation station of its unit;
- one completion buffer entry;
- one rename buffer entry, but only if it writes a register.

A slot sees the resources left over after all older slots of the same cycle have taken theirs. The block returns a grant per slot and the number of grants, so the instruction buffer can shift out that many entries. It also returns a per-unit allocation strobe and the number of rename entries taken.

The block keeps one piece of state: whether a move to a special register has been dispatched and is not yet resolved. Its two-state machine has these states and transitions:

- SPR_CLEAR: no such move is outstanding.
- SPR_PENDING: a move is outstanding, and every branch is held at dispatch.
- *mark*: from either state to SPR_PENDING, when a granted slot carries the move flag. A mark takes priority over a release in the same cycle.
- *release*: from SPR_PENDING to SPR_CLEAR, when `spr_resolved` is high and no new move is granted.
- *hold*: the state stays as it is in every other case.

Top module: `disp_alloc`

## Requirements
- R1: The grants always form a contiguous prefix starting at slot 0, and `disp_count` equals the number of grants. A slot with `slot_valid` low is never granted and blocks all younger slots.
- R2: The unit codes are 0 branch, 1 load/store, 2 simple integer A, 3 simple integer B, 4 complex integer and 5 floating point. Codes 6 and 7 are never granted. A slot is granted only if the free count of its unit's reservation station is nonzero. Field u of `rs_free` occupies bits [3u+2:3u]. `rs_alloc[u]` is high exactly when a granted slot targets unit u.
- R3: At most one slot per unit is granted in a cycle. A later slot that targets the same unit as an earlier slot is blocked.
- R4: Slot k (counted from 0) needs k+1 completion buffer entries, so `disp_count` never exceeds `cb_free`.
- R5: A slot that writes a register is granted only if the number of register-writing slots from slot 0 up to and including it is at most `rn_free`. `rn_alloc` equals the number of granted register-writing slots.
- R6: The source operand counts (0 to 3) of all slots up to and including a granted slot sum to at most 8 read ports.
- R7: A serializing slot is granted only in slot 0, and only when `cb_free` equals 16, meaning the completion buffer is empty. No slot after a serializing slot is granted in the same cycle.
- R8: A branch is blocked while the state is SPR_PENDING. A branch is also blocked when an older slot in the same cycle carries the move flag. A granted slot with the move flag enters SPR_PENDING at the next edge. `spr_resolved` returns the state to SPR_CLEAR at the next edge, unless a new move is granted in the same cycle.
- R9: After reset the state is SPR_CLEAR, so a branch in slot 0 with resources available is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_valid | input | 4 | Slot holds an instruction; bit 0 is the oldest |
| slot_unit | input | 12 | Target unit code, 3 bits per slot |
| slot_writes | input | 4 | Slot writes a register (needs a rename entry) |
| slot_nsrc | input | 8 | Source operand count, 2 bits per slot |
| slot_serial | input | 4 | Slot is serializing |
| slot_mtspr | input | 4 | Slot moves to a special register |
| rs_free | input | 18 | Free reservation station entries, 3 bits per unit |
| cb_free | input | 5 | Free completion buffer entries (0 to 16) |
| rn_free | input | 4 | Free rename buffer entries (0 to 8) |
| spr_resolved | input | 1 | The outstanding special-register move has completed |
| disp_grant | output | 4 | Per-slot dispatch grant |
| disp_count | output | 3 | Number of slots granted; also the completion entries taken |
| rs_alloc | output | 6 | Per-unit reservation station allocation strobe |
| rn_alloc | output | 3 | Rename entries taken this cycle |

## Verification
The only hidden state is the pending-move flag. If that flag is wrong, it shows up at the first branch presented after the fault: either a branch is refused while nothing is outstanding, or a branch goes out while a move is still unresolved. Every other decision is combinational in the current inputs. A fault in any of the running resource tallies therefore changes `disp_grant`, `disp_count` or `rn_alloc` in the same cycle, as soon as some input pattern reaches that tally's limit. The sweep is built so that each limit is reached often.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam logic [2:0] UNIT_BRANCH = 3'd0;

    typedef enum logic [0:0] {
        SPR_CLEAR   = 1'b0,
        SPR_PENDING = 1'b1
    } spr_state_e;

endpackage

// File: rtl/disp_slot_gate.sv
module disp_slot_gate
    import disp_pkg::*;
#(
    parameter int IDX      = 0,
    parameter int UNITS    = 6,
    parameter int UW       = 3,
    parameter int RSW      = 3,
    parameter int CBW      = 5,
    parameter int RNW      = 4,
    parameter int NW       = 6,
    parameter int RD_PORTS = 8,
    parameter int CB_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prev_ok,
    input  logic                 valid,
    input  logic [UW-1:0]        unit,
    input  logic                 serial,
    input  logic [UNITS*RSW-1:0] rs_free,
    input  logic [UNITS-1:0]     used_before,
    input  logic                 mtspr_before,
    input  logic                 serial_before,
    input  logic [CBW-1:0]       cb_free,
    input  logic [RNW-1:0]       rn_free,
    input  logic [NW-1:0]        rn_need,
    input  logic [NW-1:0]        src_need,
    input  logic                 spr_pending,
    output logic                 ok
);

    localparam logic [NW-1:0] CB_NEED = NW'(IDX + 1);

    logic unit_ok;
    logic rs_avail;
    logic unit_busy;
    logic serial_ok;
    logic branch_ok;
    logic pools_ok;
    logic local_ok;

    always_comb begin
        rs_avail  = 1'b0;
        unit_busy = 1'b0;
        for (int u = 0; u < UNITS; u++) begin
            if (unit == UW'(u)) begin
                rs_avail  = (rs_free[u*RSW +: RSW] != '0);
                unit_busy = used_before[u];
            end
        end
    end

    always_comb begin
        unit_ok   = (unit < UW'(UNITS));
        serial_ok = !serial || ((IDX == 0) && (cb_free == CBW'(CB_DEPTH)));
        branch_ok = (unit != UNIT_BRANCH) || (!spr_pending && !mtspr_before);
        pools_ok  = (CB_NEED <= NW'(cb_free)) &&
                    (rn_need <= NW'(rn_free)) &&
                    (src_need <= NW'(RD_PORTS));
        local_ok  = valid && unit_ok && rs_avail && !unit_busy && pools_ok &&
                    !serial_before && serial_ok && branch_ok;
        ok        = prev_ok && local_ok;
    end

    // R8: a branch never passes while a special-register move is outstanding
    assert_branch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_pending && unit == UNIT_BRANCH) |-> !ok);

    // R7: serializing work leaves only from slot 0 into an empty machine
    assert_serial_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && serial) |-> (IDX == 0 && cb_free == CBW'(CB_DEPTH)));

    // R1: a grant implies every older slot was granted
    assert_chain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> prev_ok);

endmodule

// File: rtl/disp_spr_fsm.sv
module disp_spr_fsm
    import disp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mtspr_granted,
    input  logic spr_resolved,
    output logic spr_pending
);

    spr_state_e state;
    spr_state_e state_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SPR_CLEAR;
        else        state <= state_next;
    end

    always_comb begin
        state_next = state;
        unique case (state)
            SPR_CLEAR: begin
                if (mtspr_granted) state_next = SPR_PENDING;
            end
            SPR_PENDING: begin
                if (!mtspr_granted && spr_resolved) state_next = SPR_CLEAR;
            end
        endcase
    end

    always_comb begin
        spr_pending = (state == SPR_PENDING);
    end

    // R8: a granted move always leaves the machine pending
    assert_pend_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mtspr_granted |=> spr_pending);

    // R8: resolution without a new move releases the hold
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_pending && spr_resolved && !mtspr_granted) |=> !spr_pending);

endmodule

// File: rtl/disp_alloc.sv
module disp_alloc
    import disp_pkg::*;
#(
    parameter int SLOTS    = 4,
    parameter int UNITS    = 6,
    parameter int RS_DEPTH = 4,
    parameter int CB_DEPTH = 16,
    parameter int RN_DEPTH = 8,
    parameter int RD_PORTS = 8,
    parameter int SRC_MAX  = 3,
    localparam int UW      = $clog2(UNITS),
    localparam int RSW     = $clog2(RS_DEPTH + 1),
    localparam int CBW     = $clog2(CB_DEPTH + 1),
    localparam int RNW     = $clog2(RN_DEPTH + 1),
    localparam int SW      = $clog2(SRC_MAX + 1),
    localparam int CNTW    = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOTS-1:0]     slot_valid,
    input  logic [SLOTS*UW-1:0]  slot_unit,
    input  logic [SLOTS-1:0]     slot_writes,
    input  logic [SLOTS*SW-1:0]  slot_nsrc,
    input  logic [SLOTS-1:0]     slot_serial,
    input  logic [SLOTS-1:0]     slot_mtspr,
    input  logic [UNITS*RSW-1:0] rs_free,
    input  logic [CBW-1:0]       cb_free,
    input  logic [RNW-1:0]       rn_free,
    input  logic                 spr_resolved,
    output logic [SLOTS-1:0]     disp_grant,
    output logic [CNTW-1:0]      disp_count,
    output logic [UNITS-1:0]     rs_alloc,
    output logic [CNTW-1:0]      rn_alloc
);

    localparam int PSW  = $clog2(SLOTS * SRC_MAX + 1);
    localparam int NW0  = (CBW > RNW) ? CBW : RNW;
    localparam int NW1  = (PSW > CNTW) ? PSW : CNTW;
    localparam int NW   = ((NW0 > NW1) ? NW0 : NW1) + 1;

    function automatic logic [UNITS-1:0] unit_bit(input logic v, input logic [UW-1:0] u);
        logic [UNITS-1:0] b;
        b = '0;
        for (int i = 0; i < UNITS; i++) begin
            if (v && u == UW'(i)) b[i] = 1'b1;
        end
        return b;
    endfunction

    logic [NW-1:0]    rn_need      [SLOTS];
    logic [NW-1:0]    src_need     [SLOTS];
    logic [UNITS-1:0] used_before  [SLOTS];
    logic             mtspr_before [SLOTS];
    logic             serial_before[SLOTS];
    logic [SLOTS:0]   chain;
    logic             spr_pending;
    logic             mtspr_granted;

    assign chain[0] = 1'b1;

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            if (k == 0) begin : g_first
                assign rn_need[k]       = NW'(slot_writes[k]);
                assign src_need[k]      = NW'(slot_nsrc[k*SW +: SW]);
                assign used_before[k]   = '0;
                assign mtspr_before[k]  = 1'b0;
                assign serial_before[k] = 1'b0;
            end else begin : g_rest
                assign rn_need[k]       = rn_need[k-1] + NW'(slot_writes[k]);
                assign src_need[k]      = src_need[k-1] + NW'(slot_nsrc[k*SW +: SW]);
                assign used_before[k]   = used_before[k-1] |
                                          unit_bit(slot_valid[k-1], slot_unit[(k-1)*UW +: UW]);
                assign mtspr_before[k]  = mtspr_before[k-1]  | (slot_valid[k-1] & slot_mtspr[k-1]);
                assign serial_before[k] = serial_before[k-1] | (slot_valid[k-1] & slot_serial[k-1]);
            end

            disp_slot_gate #(
                .IDX(k), .UNITS(UNITS), .UW(UW), .RSW(RSW), .CBW(CBW), .RNW(RNW),
                .NW(NW), .RD_PORTS(RD_PORTS), .CB_DEPTH(CB_DEPTH)
            ) u_gate (
                .clk          (clk),
                .rst_n        (rst_n),
                .prev_ok      (chain[k]),
                .valid        (slot_valid[k]),
                .unit         (slot_unit[k*UW +: UW]),
                .serial       (slot_serial[k]),
                .rs_free      (rs_free),
                .used_before  (used_before[k]),
                .mtspr_before (mtspr_before[k]),
                .serial_before(serial_before[k]),
                .cb_free      (cb_free),
                .rn_free      (rn_free),
                .rn_need      (rn_need[k]),
                .src_need     (src_need[k]),
                .spr_pending  (spr_pending),
                .ok           (chain[k+1])
            );
        end
    endgenerate

    logic [NW-1:0] granted_src;

    always_comb begin
        disp_grant    = chain[SLOTS:1];
        disp_count    = '0;
        rn_alloc      = '0;
        rs_alloc      = '0;
        mtspr_granted = 1'b0;
        granted_src   = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (disp_grant[k]) begin
                disp_count    = disp_count + CNTW'(1);
                rn_alloc      = rn_alloc + CNTW'(slot_writes[k]);
                rs_alloc      = rs_alloc | unit_bit(1'b1, slot_unit[k*UW +: UW]);
                mtspr_granted = mtspr_granted | slot_mtspr[k];
                granted_src   = granted_src + NW'(slot_nsrc[k*SW +: SW]);
            end
        end
    end

    disp_spr_fsm u_spr (
        .clk          (clk),
        .rst_n        (rst_n),
        .mtspr_granted(mtspr_granted),
        .spr_resolved (spr_resolved),
        .spr_pending  (spr_pending)
    );

    // R1: grants are a contiguous run from slot 0
    assert_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((disp_grant + 1'b1) & disp_grant) == '0);

    // R3: one strobe per granted slot means no unit got two
    assert_unit_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rs_alloc) == int'(disp_count));

    // R4: completion entries taken never exceed what is free
    assert_cb_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        NW'(disp_count) <= NW'(cb_free));

    // R5: rename entries taken never exceed what is free
    assert_rn_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        NW'(rn_alloc) <= NW'(rn_free));

    // R6: read ports are never oversubscribed
    assert_ports_R6: assert property (@(posedge clk) disable iff (!rst_n)
        granted_src <= NW'(RD_PORTS));

    generate
        for (genvar u = 0; u < UNITS; u++) begin : g_rs_chk
            // R2: a unit is allocated only when its station has room
            assert_rs_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
                rs_alloc[u] |-> (rs_free[u*RSW +: RSW] != '0));
        end
    endgenerate

endmodule

// File: tb/tb_disp_alloc.sv
module tb_disp_alloc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  v, wr, se, mt;
    int          un [4];
    int          ns [4];
    int          rs [6];
    int          cbf, rnf;
    logic        res;

    logic [11:0] p_unit;
    logic [7:0]  p_nsrc;
    logic [17:0] p_rs;
    logic [3:0]  disp_grant;
    logic [2:0]  disp_count;
    logic [5:0]  rs_alloc;
    logic [2:0]  rn_alloc;

    int checks = 0;
    int fails  = 0;
    bit pend   = 0;
    bit done   = 0;

    logic [3:0] e_grant;
    int         e_count, e_rn;
    logic [5:0] e_rs;
    bit         e_next;

    always #5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            p_unit[k*3 +: 3] = 3'(un[k]);
            p_nsrc[k*2 +: 2] = 2'(ns[k]);
        end
        for (int u = 0; u < 6; u++) p_rs[u*3 +: 3] = 3'(rs[u]);
    end

    disp_alloc dut (
        .clk(clk), .rst_n(rst_n),
        .slot_valid(v), .slot_unit(p_unit), .slot_writes(wr), .slot_nsrc(p_nsrc),
        .slot_serial(se), .slot_mtspr(mt), .rs_free(p_rs),
        .cb_free(5'(cbf)), .rn_free(4'(rnf)), .spr_resolved(res),
        .disp_grant(disp_grant), .disp_count(disp_count),
        .rs_alloc(rs_alloc), .rn_alloc(rn_alloc)
    );

    task automatic model();
        bit ok, loc, mb, sb, anymt;
        int rn, src;
        bit used [6];
        ok = 1; mb = 0; sb = 0; anymt = 0; rn = 0; src = 0;
        for (int u = 0; u < 6; u++) used[u] = 0;
        e_grant = '0; e_count = 0; e_rn = 0; e_rs = '0;
        for (int k = 0; k < 4; k++) begin
            loc = v[k] && un[k] < 6;
            if (loc) loc = rs[un[k]] != 0 && !used[un[k]];
            loc = loc && (k + 1) <= cbf && (rn + int'(wr[k])) <= rnf && (src + ns[k]) <= 8;
            loc = loc && !sb && !(se[k] && (k != 0 || cbf != 16));
            loc = loc && !(un[k] == 0 && (pend || mb));
            ok = ok && loc;
            if (ok) begin
                e_grant[k] = 1'b1;
                e_count++;
                e_rs[un[k]] = 1'b1;
                if (wr[k]) e_rn++;
                if (mt[k]) anymt = 1;
            end
            rn += int'(wr[k]);
            src += ns[k];
            if (v[k] && un[k] < 6) used[un[k]] = 1;
            mb = mb || (v[k] && mt[k]);
            sb = sb || (v[k] && se[k]);
        end
        e_next = anymt ? 1'b1 : (res ? 1'b0 : pend);
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(string tag);
        model();
        #1;
        chk(tag, "grant", int'(disp_grant), int'(e_grant));
        chk(tag, "count", int'(disp_count), e_count);
        chk(tag, "rs_alloc", int'(rs_alloc), int'(e_rs));
        chk(tag, "rn_alloc", int'(rn_alloc), e_rn);
        @(posedge clk);
        pend = e_next;
        @(negedge clk);
    endtask

    task automatic base();
        v = 4'hF; wr = 4'h0; se = 4'h0; mt = 4'h0; res = 1'b0;
        for (int k = 0; k < 4; k++) begin un[k] = k; ns[k] = 1; end
        for (int u = 0; u < 6; u++) rs[u] = 4;
        cbf = 16; rnf = 8;
    endtask

    initial begin
        #(190000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        base();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: branch in slot 0 right after reset
        base(); apply("R9");
        base(); wr = 4'hF; apply("R1");
        base(); un[2] = 2; apply("R3");
        base(); rs[1] = 0; apply("R2");
        base(); un[1] = 6; apply("R2");
        base(); v[2] = 1'b0; apply("R1");
        base(); cbf = 2; apply("R4");
        base(); cbf = 0; apply("R4");
        base(); wr = 4'hF; rnf = 1; apply("R5");
        base(); wr = 4'b1010; rnf = 1; apply("R5");
        base(); ns[0] = 3; ns[1] = 3; ns[2] = 3; apply("R6");
        base(); ns[0] = 3; ns[1] = 3; ns[2] = 2; ns[3] = 0; apply("R6");
        base(); se[0] = 1'b1; apply("R7");
        base(); se[0] = 1'b1; cbf = 15; apply("R7");
        base(); se[1] = 1'b1; apply("R7");
        // R8: same-cycle and pending holds, then release
        base(); un[0] = 2; un[1] = 0; un[2] = 1; un[3] = 3; mt[0] = 1'b1; apply("R8");
        base(); apply("R8");
        base(); res = 1'b1; apply("R8");
        base(); apply("R8");
        base(); un[0] = 2; un[1] = 0; mt[0] = 1'b1; res = 1'b1; apply("R8");
        base(); apply("R8");

        for (int n = 0; n < 6000; n++) begin
            for (int k = 0; k < 4; k++) begin
                v[k]  = ($urandom_range(0, 9) != 0);
                un[k] = ($urandom_range(0, 11) == 0) ? $urandom_range(6, 7) : $urandom_range(0, 5);
                wr[k] = $urandom_range(0, 1);
                ns[k] = $urandom_range(0, 3);
                se[k] = ($urandom_range(0, 19) == 0);
                mt[k] = ($urandom_range(0, 11) == 0);
            end
            for (int u = 0; u < 6; u++) rs[u] = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 4);
            cbf = ($urandom_range(0, 3) == 0) ? 16 : $urandom_range(0, 16);
            rnf = $urandom_range(0, 8);
            res = ($urandom_range(0, 2) == 0);
            apply("R1");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule